// File: doc/BRIEF.md
# Sleep and Wake-up Sequencer

This block controls the low-power state of a small 8-bit microcontroller core. The core's decoder raises a one-cycle strobe when it executes the power-down instruction. In that same cycle the block looks at every interrupt source whose flag and enable are both set. If such a source is already pending, the instruction acts as a no-op and nothing changes. Otherwise the block stops the core clock, pulses a watchdog clear, and updates two status bits. The power-down bit goes low and the time-out bit goes high.

While the core clock is stopped, the block runs from an always-on clock. It watches only three kinds of asynchronous event: an external reset request, a watchdog time-out, and interrupt flags. Each of these passes through a synchronizer before it can act. When one arrives, the block restarts the core clock and issues a one-cycle resume strobe with a resume action. The action tells the core either to continue at the prefetched next instruction, to continue and then branch to the interrupt vector at 0x0004, or to perform a full reset. A vector-pending level stays high until the prefetched instruction retires, so the fetch logic can insert the branch at the right point.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After power-on reset, pd_bit=1, to_bit=1, core_clk_en=1, wdt_clr=0, resume_stb=0 and vec_pending=0.
- R2: A sleep strobe while running, with no source having both flag and enable set, gives pd_bit=0, to_bit=1 and core_clk_en=0 on the next cycle. It also gives wdt_clr=1 for exactly that one cycle.
- R3: A sleep strobe while some source has both its flag and its enable set makes the instruction a no-op. pd_bit and to_bit keep their values, core_clk_en stays 1 and wdt_clr stays 0. A flag whose own enable is clear does not cause the no-op.
- R4: While asleep, an interrupt flag wakes the block only if that source's enable bit is set. A flag with its enable clear leaves core_clk_en at 0 and resume_stb at 0.
- R5: A watchdog time-out while asleep wakes the block and clears to_bit. The resume action is continue (0), or continue-then-vector (1) if an enabled interrupt wakes in the same cycle with gie=1.
- R6: An external reset request while asleep has top priority. It gives resume action reset (2) and vec_pending=0, and leaves pd_bit=0 and to_bit=1.
- R7: An interrupt wake happens whatever gie is. With gie=0 the resume action is 0 and vec_pending stays 0. With gie=1 the resume action is 1 and vec_pending becomes 1.
- R8: vec_pending, once set, holds until the first instr_retire pulse while running, and falls on the cycle after that pulse.
- R9: A wake event held steady from a falling edge appears on the outputs after the third rising edge (two synchronizer stages plus the state register). core_clk_en stays 0 before that edge. At that edge core_clk_en returns to 1 and resume_stb is high for exactly one cycle.
- R10: While running, wdt_timeout and ext_rst_req have no effect. While asleep, a sleep strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| sleep_stb | input | 1 | Decoded power-down instruction, one cycle |
| instr_retire | input | 1 | Core retired an instruction |
| gie | input | 1 | Global interrupt enable |
| irq_flag | input | IRQ_N | Interrupt flags, asynchronous while asleep |
| irq_en | input | IRQ_N | Per-source interrupt enables |
| wdt_timeout | input | 1 | Watchdog time-out, asynchronous |
| ext_rst_req | input | 1 | External reset request, asynchronous |
| core_clk_en | output | 1 | Core clock gate enable |
| wdt_clr | output | 1 | Clears watchdog and postscaler, one cycle |
| pd_bit | output | 1 | Power-down status bit |
| to_bit | output | 1 | Time-out status bit |
| resume_stb | output | 1 | One-cycle wake strobe |
| resume_act | output | 2 | 0 continue, 1 continue then vector, 2 reset |
| vec_pending | output | 1 | Branch to interrupt vector after the prefetched instruction |

## Verification
The hardest case to reach is the boundary between a no-op sleep and a real one. The outcome depends on which flag and enable bits coincide in the single strobe cycle. The bench covers this by sweeping every flag pattern against every enable pattern on the strobe cycle, including patterns where flags are set only on disabled sources. It also raises each source while asleep under every combination of its own enable and gie. It counts edges to pin the synchronizer latency, and it ends each sleep through a watchdog wake so the status bits trace a known history.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    RES_CONT  = 2'd0,
    RES_VEC   = 2'd1,
    RES_RESET = 2'd2
  } resume_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_DOZE = 1'b1
  } pwr_state_e;
endpackage

// File: rtl/swk_rst_sync.sv
module swk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  // asserts at once, releases after STAGES edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/swk_sync.sv
module swk_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= {st_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = st_q[STAGES-1];
endmodule

// File: rtl/swk_wake_eval.sv
module swk_wake_eval #(
  parameter int unsigned IRQ_N = 4
) (
  input  logic [IRQ_N-1:0] irq_flag,
  input  logic [IRQ_N-1:0] irq_flag_s,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             rst_s,
  input  logic             wdt_s,
  output logic             pend_now,
  output logic             wake_rst,
  output logic             wake_wdt,
  output logic             wake_irq,
  output logic             wake_any
);
  logic [IRQ_N-1:0] qual_now;
  logic [IRQ_N-1:0] qual_sync;

  genvar g;
  generate
    for (g = 0; g < IRQ_N; g++) begin : g_src
      assign qual_now[g]  = irq_flag[g]   & irq_en[g];
      assign qual_sync[g] = irq_flag_s[g] & irq_en[g];
    end
  endgenerate

  assign pend_now = |qual_now;
  assign wake_rst = rst_s;
  assign wake_wdt = wdt_s;
  assign wake_irq = |qual_sync;
  assign wake_any = wake_rst | wake_wdt | wake_irq;
endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swk_pkg::*;
#(
  parameter int unsigned IRQ_N       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_stb,
  input  logic             instr_retire,
  input  logic             gie,
  input  logic [IRQ_N-1:0] irq_flag,
  input  logic [IRQ_N-1:0] irq_en,
  input  logic             wdt_timeout,
  input  logic             ext_rst_req,
  output logic             core_clk_en,
  output logic             wdt_clr,
  output logic             pd_bit,
  output logic             to_bit,
  output logic             resume_stb,
  output logic [1:0]       resume_act,
  output logic             vec_pending
);
  localparam int unsigned SW = IRQ_N + 2;

  logic          srst_n;
  logic [SW-1:0] async_in, sync_out;
  logic [IRQ_N-1:0] irq_flag_s;
  logic          rst_s, wdt_s;
  logic          pend_now, wake_rst, wake_wdt, wake_irq, wake_any;

  pwr_state_e state_q, state_d;
  logic       pd_q, pd_d, to_q, to_d, clk_en_q, clk_en_d;
  logic       wclr_q, wclr_d, rstb_q, rstb_d, vec_q, vec_d;
  resume_e    act_q, act_d;
  logic       upd_en;

  swk_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  assign async_in = {ext_rst_req, wdt_timeout, irq_flag};

  swk_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(srst_n), .d(async_in), .q(sync_out)
  );

  assign rst_s      = sync_out[SW-1];
  assign wdt_s      = sync_out[SW-2];
  assign irq_flag_s = sync_out[IRQ_N-1:0];

  swk_wake_eval #(.IRQ_N(IRQ_N)) u_eval (
    .irq_flag(irq_flag), .irq_flag_s(irq_flag_s), .irq_en(irq_en),
    .rst_s(rst_s), .wdt_s(wdt_s),
    .pend_now(pend_now), .wake_rst(wake_rst), .wake_wdt(wake_wdt),
    .wake_irq(wake_irq), .wake_any(wake_any)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pd_d     = pd_q;
    to_d     = to_q;
    clk_en_d = clk_en_q;
    act_d    = act_q;
    vec_d    = vec_q;
    wclr_d   = 1'b0;
    rstb_d   = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (instr_retire) vec_d = 1'b0;
        if (sleep_stb && !pend_now) begin
          state_d  = ST_DOZE;
          pd_d     = 1'b0;
          to_d     = 1'b1;
          clk_en_d = 1'b0;
          wclr_d   = 1'b1;
        end
      end
      ST_DOZE: begin
        if (wake_any) begin
          state_d  = ST_RUN;
          clk_en_d = 1'b1;
          rstb_d   = 1'b1;
          if (wake_rst) begin
            act_d = RES_RESET;
            vec_d = 1'b0;
          end else begin
            if (wake_wdt) to_d = 1'b0;
            if (wake_irq && gie) begin
              act_d = RES_VEC;
              vec_d = 1'b1;
            end else begin
              act_d = RES_CONT;
              vec_d = 1'b0;
            end
          end
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  // pulse registers always update; held state only when something changes
  assign upd_en = (state_q == ST_RUN) ? (sleep_stb | instr_retire) : wake_any;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wclr_q <= 1'b0;
      rstb_q <= 1'b0;
    end else begin
      wclr_q <= wclr_d;
      rstb_q <= rstb_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q  <= ST_RUN;
      pd_q     <= 1'b1;
      to_q     <= 1'b1;
      clk_en_q <= 1'b1;
      act_q    <= RES_CONT;
      vec_q    <= 1'b0;
    end else if (upd_en) begin
      state_q  <= state_d;
      pd_q     <= pd_d;
      to_q     <= to_d;
      clk_en_q <= clk_en_d;
      act_q    <= act_d;
      vec_q    <= vec_d;
    end
  end

  assign core_clk_en = clk_en_q;
  assign wdt_clr     = wclr_q;
  assign pd_bit      = pd_q;
  assign to_bit      = to_q;
  assign resume_stb  = rstb_q;
  assign resume_act  = act_q;
  assign vec_pending = vec_q;

  // R2: executed sleep side effects
  a_r2_sleep_effects: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_RUN && sleep_stb && !pend_now) |=>
      (!pd_bit && to_bit && !core_clk_en && wdt_clr));

  // R3: no-op sleep leaves status untouched
  a_r3_noop_sleep: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_RUN && sleep_stb && pend_now) |=>
      ($stable(pd_bit) && $stable(to_bit) && core_clk_en && !wdt_clr));

  // R5: watchdog wake clears the time-out bit
  a_r5_wdt_clears_to: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_DOZE && wake_wdt && !wake_rst) |=> !to_bit);

  // R6: reset wake never leaves a vector pending
  a_r6_reset_no_vec: assert property (@(posedge clk) disable iff (!srst_n)
    (resume_stb && resume_act == RES_RESET) |-> !vec_pending);

  // R8: retire drops vector pending
  a_r8_vec_release: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_RUN && vec_pending && instr_retire) |=> !vec_pending);

  // R9: resume strobe is one cycle and comes with the clock on
  a_r9_resume_pulse: assert property (@(posedge clk) disable iff (!srst_n)
    resume_stb |=> !resume_stb);
  a_r9_resume_clk: assert property (@(posedge clk) disable iff (!srst_n)
    resume_stb |-> core_clk_en);
endmodule

// File: tb/sleep_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_tb_top;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n, sleep_stb, instr_retire, gie, wdt_timeout, ext_rst_req;
  logic [N-1:0] irq_flag, irq_en;
  logic         core_clk_en, wdt_clr, pd_bit, to_bit, resume_stb, vec_pending;
  logic [1:0]   resume_act;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl #(.IRQ_N(N), .SYNC_STAGES(2), .RST_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .instr_retire(instr_retire),
    .gie(gie), .irq_flag(irq_flag), .irq_en(irq_en), .wdt_timeout(wdt_timeout),
    .ext_rst_req(ext_rst_req), .core_clk_en(core_clk_en), .wdt_clr(wdt_clr),
    .pd_bit(pd_bit), .to_bit(to_bit), .resume_stb(resume_stb),
    .resume_act(resume_act), .vec_pending(vec_pending)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sleep_stb = 0; instr_retire = 0; gie = 0;
    irq_flag = '0; irq_en = '0; wdt_timeout = 0; ext_rst_req = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic do_sleep();
    @(negedge clk) sleep_stb = 1'b1;
    tick();
    @(negedge clk) sleep_stb = 1'b0;
  endtask

  task automatic wdt_exit();
    @(negedge clk) wdt_timeout = 1'b1;
    repeat (3) tick();
    @(negedge clk) wdt_timeout = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pd", pd_bit, 1);
    chk("R1 to", to_bit, 1);
    chk("R1 clk_en", core_clk_en, 1);
    chk("R1 wdt_clr", wdt_clr, 0);
    chk("R1 resume_stb", resume_stb, 0);
    chk("R1 vec", vec_pending, 0);

    // R2 / R3: every flag pattern against every enable pattern at the strobe
    for (int f = 0; f < 16; f++) begin
      for (int e = 0; e < 16; e++) begin
        bit pend;
        pend = |(f[N-1:0] & e[N-1:0]);
        do_reset();
        @(negedge clk);
        irq_flag = f[N-1:0]; irq_en = e[N-1:0]; sleep_stb = 1'b1;
        tick();
        if (pend) begin
          chk("R3 pd", pd_bit, 1);
          chk("R3 to", to_bit, 1);
          chk("R3 clk_en", core_clk_en, 1);
          chk("R3 wdt_clr", wdt_clr, 0);
        end else begin
          chk("R2 pd", pd_bit, 0);
          chk("R2 to", to_bit, 1);
          chk("R2 clk_en", core_clk_en, 0);
          chk("R2 wdt_clr", wdt_clr, 1);
        end
        @(negedge clk); sleep_stb = 1'b0; irq_flag = '0;
        if (!pend) begin
          tick();
          chk("R2 wdt_clr one cycle", wdt_clr, 0);
          chk("R2 stays asleep", core_clk_en, 0);
          wdt_exit();
        end
      end
    end

    // R4 / R7 / R8 / R9: each source, own enable on/off, gie on/off
    for (int i = 0; i < N; i++) begin
      for (int eb = 0; eb < 2; eb++) begin
        for (int g = 0; g < 2; g++) begin
          do_reset();
          @(negedge clk);
          irq_en = (eb != 0) ? (N'(1) << i) : (~(N'(1) << i));
          gie = g[0];
          do_sleep();
          @(negedge clk) irq_flag = N'(1) << i;
          tick(); chk("R9 latency edge1", core_clk_en, 0);
          tick(); chk("R9 latency edge2", core_clk_en, 0);
          tick();
          if (eb != 0) begin
            chk("R4 wake stb", resume_stb, 1);
            chk("R9 clk back", core_clk_en, 1);
            chk("R7 act", resume_act, g);
            chk("R7 vec", vec_pending, g);
            chk("R4 pd", pd_bit, 0);
            chk("R4 to", to_bit, 1);
            @(negedge clk) irq_flag = '0;
            tick(); chk("R9 stb one cycle", resume_stb, 0);
            if (g != 0) begin
              tick(); chk("R8 vec held", vec_pending, 1);
              @(negedge clk) instr_retire = 1'b1;
              tick(); chk("R8 vec cleared", vec_pending, 0);
              @(negedge clk) instr_retire = 1'b0;
            end
          end else begin
            chk("R4 no wake stb", resume_stb, 0);
            chk("R4 no wake clk", core_clk_en, 0);
            repeat (3) tick();
            chk("R4 still asleep", core_clk_en, 0);
            @(negedge clk) irq_flag = '0;
            wdt_exit();
          end
        end
      end
    end

    // R5: watchdog wake alone
    do_reset();
    do_sleep();
    @(negedge clk) wdt_timeout = 1'b1;
    repeat (3) tick();
    chk("R5 stb", resume_stb, 1);
    chk("R5 act", resume_act, 0);
    chk("R5 to", to_bit, 0);
    chk("R5 vec", vec_pending, 0);
    @(negedge clk) wdt_timeout = 1'b0;
    repeat (3) tick();

    // R5: watchdog plus enabled interrupt with gie
    do_reset();
    @(negedge clk) begin irq_en = 4'b0010; gie = 1'b1; end
    do_sleep();
    @(negedge clk) begin wdt_timeout = 1'b1; irq_flag = 4'b0010; end
    repeat (3) tick();
    chk("R5 wdt+irq act", resume_act, 1);
    chk("R5 wdt+irq to", to_bit, 0);
    chk("R5 wdt+irq vec", vec_pending, 1);
    @(negedge clk) begin wdt_timeout = 1'b0; irq_flag = '0; end
    repeat (3) tick();

    // R6: external reset beats every other event
    do_reset();
    @(negedge clk) begin irq_en = 4'b1111; gie = 1'b1; end
    do_sleep();
    @(negedge clk) begin ext_rst_req = 1'b1; wdt_timeout = 1'b1; irq_flag = 4'b0100; end
    repeat (3) tick();
    chk("R6 stb", resume_stb, 1);
    chk("R6 act", resume_act, 2);
    chk("R6 vec", vec_pending, 0);
    chk("R6 pd", pd_bit, 0);
    chk("R6 to", to_bit, 1);
    @(negedge clk) begin ext_rst_req = 1'b0; wdt_timeout = 1'b0; irq_flag = '0; end
    repeat (3) tick();

    // R10: wake inputs ignored while running
    do_reset();
    @(negedge clk) begin wdt_timeout = 1'b1; ext_rst_req = 1'b1; end
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R10 run stb", resume_stb, 0);
      chk("R10 run to", to_bit, 1);
      chk("R10 run clk", core_clk_en, 1);
    end
    @(negedge clk) begin wdt_timeout = 1'b0; ext_rst_req = 1'b0; end
    repeat (3) tick();
    chk("R10 run act", resume_act, 0);

    // R10: sleep strobe ignored while asleep
    do_sleep();
    repeat (2) tick();
    @(negedge clk) sleep_stb = 1'b1;
    tick();
    chk("R10 doze wdt_clr", wdt_clr, 0);
    chk("R10 doze clk", core_clk_en, 0);
    chk("R10 doze stb", resume_stb, 0);
    @(negedge clk) sleep_stb = 1'b0;
    wdt_exit();
    chk("R10 exit to", to_bit, 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 150000);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule